// File: doc/BRIEF.md
# Packed-Sample Result FIFO

This block buffers 12-bit conversion results coming from one of four logical channels and hands them to a CPU or DMA reader two at a time. A 2-bit select picks the channel whose write strobe, sample and end-of-batch marker are accepted. An enable input gates every write. Each sample is kept with its end-of-batch marker. One read strobe pops up to two samples and returns them in a registered 32-bit word. Each half of that word carries a 2-bit tag that says whether the slot holds ordinary data, the final sample of a batch, or nothing.

The block also reports its fill state and its events. It drives an entry count with empty and full bits. It drives a watermark level compare. It keeps sticky overrun, underrun and last-sample-read flags, and each of these is cleared by a write-one-to-clear strobe. A synchronous clear input flushes the storage and clears every flag. Only the FIFO is built here; the DMA engine that drains it sits outside.

Top module: `sfifo_top`

## Requirements
- R1: After rst_ni is asserted, and in the cycle after fifo_clr_i is sampled high, count_o is 0, empty_o is 1, full_o is 0, ovr_o, udr_o and last_rd_o are 0, and rd_data_o is 0.
- R2: Only the channel addressed by ch_sel_i (0..3) is written. Its sample is taken from smp_data_i[12*k+11:12*k]. Strobes on the other channels have no effect.
- R3: While fifo_en_i is 0 no sample is stored and no overrun is flagged.
- R4: When rd_i is sampled high, rd_data_o is updated at that edge, with slot 0 data in bits 11:0 and its tag in 15:14, and slot 1 data in bits 27:16 and its tag in 31:30. Bits 13:12 and 29:28 are 0. Tag codes are 0 for default, 1 for valid, 2 for the last sample of a batch (its marker was set on write), and 3 for invalid. Without a read, rd_data_o holds its value.
- R5: Samples come out in write order, and slot 0 holds the older of the two.
- R6: A read with exactly one sample stored pops it into slot 0, and slot 1 is tagged 3 with data 0.
- R7: A read while empty returns both slots tagged 3 with data 0 and sets the sticky underrun flag udr_o.
- R8: The depth is 32. A write accepted while count_o is 32 is dropped, the stored samples are unchanged, and the sticky overrun flag ovr_o is set. Fullness is taken from the count before any read in the same cycle.
- R9: count_o (6 bits) ranges from 0 to 32. empty_o is 1 exactly when the count is 0, and full_o is 1 exactly when the count is 32.
- R10: wm_o is 1 exactly when count_o is greater than or equal to wm_lvl_i. It follows the inputs combinationally.
- R11: last_rd_o is set sticky when a read pops a sample whose end-of-batch marker was set.
- R12: flag_w1c_i bit 0 clears ovr_o, bit 1 clears udr_o and bit 2 clears last_rd_o. A new setting event in the same cycle wins over the clear.
- R13: A write and a read in the same cycle both take effect, and the count changes by the number written minus the number popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_clr_i | input | 1 | Synchronous flush of samples and flags |
| fifo_en_i | input | 1 | Write gate |
| ch_sel_i | input | 2 | Logical channel feeding the FIFO |
| smp_vld_i | input | 4 | Per-channel sample write strobes |
| smp_data_i | input | 48 | Per-channel 12-bit samples, channel k at bits 12k+11:12k |
| smp_last_i | input | 4 | Per-channel end-of-batch markers |
| rd_i | input | 1 | Read strobe, pops up to two samples |
| wm_lvl_i | input | 5 | Watermark level |
| flag_w1c_i | input | 3 | Write-one-to-clear for overrun, underrun and last-read flags |
| rd_data_o | output | 32 | Registered packed read word |
| count_o | output | 6 | Stored sample count |
| empty_o | output | 1 | Count is zero |
| full_o | output | 1 | Count equals depth |
| wm_o | output | 1 | Count at or above watermark |
| ovr_o | output | 1 | Sticky overrun |
| udr_o | output | 1 | Sticky underrun |
| last_rd_o | output | 1 | Sticky last-sample-read |

## Verification
The FIFO is filled from empty through every count up to one write past full. At each count, wm_lvl_i is swept over all 32 levels, which separates a greater-or-equal compare from a strict one and exposes an off-by-one full or overrun limit. It is then drained in pairs, then read once more while empty, and then read with odd counts that leave one sample, which separates correct ordering, single-slot invalid tagging, last tagging and underrun. Each channel select is driven with all four channels active and with only the unselected ones active. Combined write-and-read cycles start from counts 0 to 3. Flushes and the disabled state are checked against the same queue model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int SMP_W  = 12;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    TAG_NONE    = 2'd0,
    TAG_VALID   = 2'd1,
    TAG_LAST    = 2'd2,
    TAG_INVALID = 2'd3
  } tag_e;

  typedef struct packed {
    logic             last;
    logic [SMP_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/sfifo_src_sel.sv
module sfifo_src_sel
  import sfifo_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SW = $clog2(NCH)
) (
  input  logic [SW-1:0]        sel_i,
  input  logic [NCH-1:0]       vld_i,
  input  logic [NCH*SMP_W-1:0] data_i,
  input  logic [NCH-1:0]       last_i,
  output logic                 vld_o,
  output entry_t               entry_o
);
  entry_t ch_entry [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_entry[k].data = data_i[k*SMP_W +: SMP_W];
    assign ch_entry[k].last = last_i[k];
  end

  assign vld_o   = vld_i[sel_i];
  assign entry_o = ch_entry[sel_i];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  entry_t     wdat_i,
  input  logic [1:0] pop_n_i,
  output entry_t     head0_o,
  output entry_t     head1_o
);
  entry_t         mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= wdat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + AW'(1);
      rp_q <= rp_q + AW'(pop_n_i);
    end
  end

  assign head0_o = mem[rp_q];
  assign head1_o = mem[rp_q + AW'(1)];
endmodule

// File: rtl/sfifo_pack.sv
module sfifo_pack
  import sfifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic              rd_i,
  input  logic [CW-1:0]     cnt_i,
  input  entry_t            head0_i,
  input  entry_t            head1_i,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        pop_n_o,
  output logic              last_hit_o,
  output logic              udr_evt_o
);
  tag_e             tag0, tag1;
  logic [SMP_W-1:0] d0, d1;
  logic             has1, has2;

  assign has1 = (cnt_i != '0);
  assign has2 = (cnt_i > CW'(1));

  always_comb begin
    tag0 = TAG_INVALID;
    tag1 = TAG_INVALID;
    d0   = '0;
    d1   = '0;
    if (has1) begin
      tag0 = head0_i.last ? TAG_LAST : TAG_VALID;
      d0   = head0_i.data;
    end
    if (has2) begin
      tag1 = head1_i.last ? TAG_LAST : TAG_VALID;
      d1   = head1_i.data;
    end
  end

  assign word_o     = {tag1, 2'b00, d1, tag0, 2'b00, d0};
  assign pop_n_o    = !rd_i ? 2'd0 : has2 ? 2'd2 : has1 ? 2'd1 : 2'd0;
  assign last_hit_o = rd_i && ((has1 && head0_i.last) || (has2 && head1_i.last));
  assign udr_evt_o  = rd_i && !has1;
endmodule

// File: rtl/sfifo_sticky.sv
module sfifo_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (clr_i)    q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (w1c_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NCH   = 4,
  parameter int WMW   = 5,
  localparam int SW   = $clog2(NCH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fifo_clr_i,
  input  logic                 fifo_en_i,
  input  logic [SW-1:0]        ch_sel_i,
  input  logic [NCH-1:0]       smp_vld_i,
  input  logic [NCH*SMP_W-1:0] smp_data_i,
  input  logic [NCH-1:0]       smp_last_i,
  input  logic                 rd_i,
  input  logic [WMW-1:0]       wm_lvl_i,
  input  logic [2:0]           flag_w1c_i,
  output logic [WORD_W-1:0]    rd_data_o,
  output logic [CW-1:0]        count_o,
  output logic                 empty_o,
  output logic                 full_o,
  output logic                 wm_o,
  output logic                 ovr_o,
  output logic                 udr_o,
  output logic                 last_rd_o
);
  logic              src_vld, push_req, push, ovr_evt, last_hit, udr_evt, rd_eff;
  entry_t            src_entry, head0, head1;
  logic [1:0]        pop_n;
  logic [WORD_W-1:0] word;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        flags;

  sfifo_src_sel #(.NCH(NCH)) u_sel (
    .sel_i  (ch_sel_i),
    .vld_i  (smp_vld_i),
    .data_i (smp_data_i),
    .last_i (smp_last_i),
    .vld_o  (src_vld),
    .entry_o(src_entry)
  );

  assign push_req = fifo_en_i && src_vld && !fifo_clr_i;
  assign push     = push_req && !full_o;
  assign ovr_evt  = push_req && full_o;
  assign rd_eff   = rd_i && !fifo_clr_i;

  sfifo_pack #(.CW(CW)) u_pack (
    .rd_i      (rd_eff),
    .cnt_i     (cnt_q),
    .head0_i   (head0),
    .head1_i   (head1),
    .word_o    (word),
    .pop_n_o   (pop_n),
    .last_hit_o(last_hit),
    .udr_evt_o (udr_evt)
  );

  sfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fifo_clr_i),
    .push_i (push),
    .wdat_i (src_entry),
    .pop_n_i(pop_n),
    .head0_o(head0),
    .head1_o(head1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rd_data_o <= '0;
    end else if (fifo_clr_i) begin
      cnt_q     <= '0;
      rd_data_o <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(push) - CW'(pop_n);
      if (rd_i) rd_data_o <= word;
    end
  end

  sfifo_sticky #(.N(3)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (fifo_clr_i),
    .set_i ({last_hit, udr_evt, ovr_evt}),
    .w1c_i (flag_w1c_i),
    .q_o   (flags)
  );

  assign count_o   = cnt_q;
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign wm_o      = int'(cnt_q) >= int'(wm_lvl_i);
  assign ovr_o     = flags[0];
  assign udr_o     = flags[1];
  assign last_rd_o = flags[2];
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NCH   = 4,
  parameter int WMW   = 5,
  localparam int SW   = $clog2(NCH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fifo_clr_i,
  input logic                 fifo_en_i,
  input logic [SW-1:0]        ch_sel_i,
  input logic [NCH-1:0]       smp_vld_i,
  input logic [NCH*SMP_W-1:0] smp_data_i,
  input logic [NCH-1:0]       smp_last_i,
  input logic                 rd_i,
  input logic [WMW-1:0]       wm_lvl_i,
  input logic [2:0]           flag_w1c_i,
  input logic [WORD_W-1:0]    rd_data_o,
  input logic [CW-1:0]        count_o,
  input logic                 empty_o,
  input logic                 full_o,
  input logic                 wm_o,
  input logic                 ovr_o,
  input logic                 udr_o,
  input logic                 last_rd_o
);
  assert_flush_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (count_o == '0) && !ovr_o && !udr_o && !last_rd_o && (rd_data_o == '0));

  assert_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && !rd_i && !fifo_clr_i |=> count_o == $past(count_o));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !fifo_clr_i |=> $stable(rd_data_o));

  assert_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !fifo_clr_i && (count_o == CW'(1)) |=>
      (rd_data_o[31:30] == 2'b11) && (rd_data_o[27:16] == '0) && (rd_data_o[15:14] != 2'b11));

  assert_underrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && empty_o && !fifo_clr_i |=>
      udr_o && (rd_data_o[31:30] == 2'b11) && (rd_data_o[15:14] == 2'b11));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && smp_vld_i[ch_sel_i] && full_o && !fifo_clr_i |=> ovr_o && (count_o <= CW'(DEPTH)));

  assert_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o) && (count_o <= CW'(DEPTH)));

  assert_step_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_clr_i |=> (int'(count_o) <= int'($past(count_o)) + 1) &&
                    (int'(count_o) + 2 >= int'($past(count_o))));
endmodule

bind sfifo_top sfifo_chk #(.DEPTH(DEPTH), .NCH(NCH), .WMW(WMW)) u_sfifo_chk (.*);

// File: tb/test_sfifo_top.sv
module test_sfifo_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_clr_i = 1'b0;
  logic        fifo_en_i = 1'b1;
  logic [1:0]  ch_sel_i = '0;
  logic [3:0]  smp_vld_i = '0;
  logic [47:0] smp_data_i = '0;
  logic [3:0]  smp_last_i = '0;
  logic        rd_i = 1'b0;
  logic [4:0]  wm_lvl_i = '0;
  logic [2:0]  flag_w1c_i = '0;
  logic [31:0] rd_data_o;
  logic [5:0]  count_o;
  logic        empty_o, full_o, wm_o, ovr_o, udr_o, last_rd_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int q[$];
  logic [31:0] m_word = '0;
  bit m_ovr = 0, m_udr = 0, m_last = 0;

  always #10 clk_i = ~clk_i;

  sfifo_top i_sfifo_top (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, "/R9"}, "count", int'(count_o), q.size());
    chk({ctx, "/R9"}, "empty", int'(empty_o), int'(q.size() == 0));
    chk({ctx, "/R9"}, "full", int'(full_o), int'(q.size() == 32));
    chk({ctx, "/R8"}, "ovr", int'(ovr_o), int'(m_ovr));
    chk({ctx, "/R7"}, "udr", int'(udr_o), int'(m_udr));
    chk({ctx, "/R11"}, "last", int'(last_rd_o), int'(m_last));
    chk({ctx, "/R4"}, "word", int'(rd_data_o), int'(m_word));
  endtask

  function automatic logic [15:0] half(input int e);
    logic [1:0] t;
    t = e[12] ? 2'd2 : 2'd1;
    return {t, 2'b00, 12'(e)};
  endfunction

  // one clock cycle: drive, model, sample at the following falling edge
  task automatic step(input string ctx, input logic [3:0] v, input logic [11:0] d,
                      input logic lst, input logic rd, input logic [2:0] w1c, input logic clr);
    int n;
    bit full_pre, wr_ok, so, su, sl;
    int e;
    smp_vld_i  = v;
    smp_last_i = {4{lst}};
    for (int k = 0; k < 4; k++) smp_data_i[k*12 +: 12] = d + 12'(k * 256);
    rd_i = rd; flag_w1c_i = w1c; fifo_clr_i = clr;
    so = 0; su = 0; sl = 0;
    if (clr) begin
      q.delete(); m_word = '0; m_ovr = 0; m_udr = 0; m_last = 0;
    end else begin
      full_pre = (q.size() == 32);
      wr_ok = fifo_en_i && v[ch_sel_i];
      e = int'(d + 12'(int'(ch_sel_i) * 256)) | (lst ? 4096 : 0);
      if (rd) begin
        n = q.size();
        if (n == 0) begin
          m_word = 32'hC000_C000; su = 1;
        end else begin
          m_word[15:0] = half(q[0]);
          m_word[31:16] = (n >= 2) ? half(q[1]) : 16'hC000;
          if (q[0][12]) sl = 1;
          void'(q.pop_front());
          if (n >= 2) begin
            if (q[0][12]) sl = 1;
            void'(q.pop_front());
          end
        end
      end
      if (wr_ok) begin
        if (full_pre) so = 1;
        else q.push_back(e);
      end
      m_ovr  = so | (m_ovr  & ~w1c[0]);
      m_udr  = su | (m_udr  & ~w1c[1]);
      m_last = sl | (m_last & ~w1c[2]);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    smp_vld_i = '0; rd_i = 0; flag_w1c_i = '0; fifo_clr_i = 0;
    check_all(ctx);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // fill past full with watermark sweep at each count
    for (int i = 0; i < 33; i++) begin
      step("R8", 4'b0001, 12'(i * 37 + 5), 1'b0, 1'b0, 3'b000, 1'b0);
      for (int l = 0; l < 32; l++) begin
        wm_lvl_i = 5'(l);
        #1;
        chk("R10", "wm", int'(wm_o), int'(q.size() >= l));
      end
    end
    // drain in pairs, then read while empty
    for (int i = 0; i < 16; i++) step("R5", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
    step("R7", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
    step("R4", 4'b0, 12'h0, 1'b0, 1'b0, 3'b000, 1'b0);
    step("R12", 4'b0, 12'h0, 1'b0, 1'b0, 3'b011, 1'b0);

    // odd count with end-of-batch marker
    step("R6", 4'b0001, 12'h111, 1'b0, 1'b0, 3'b000, 1'b0);
    step("R6", 4'b0001, 12'h222, 1'b0, 1'b0, 3'b000, 1'b0);
    step("R6", 4'b0001, 12'h333, 1'b1, 1'b0, 3'b000, 1'b0);
    step("R6", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
    step("R11", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
    // set wins over a same-cycle clear
    step("R12", 4'b0, 12'h0, 1'b0, 1'b1, 3'b010, 1'b0);
    step("R12", 4'b0, 12'h0, 1'b0, 1'b0, 3'b110, 1'b0);

    // channel select
    for (int s = 0; s < 4; s++) begin
      ch_sel_i = 2'(s);
      step("R2", 4'hF, 12'(8'hA0 + s), 1'b0, 1'b0, 3'b000, 1'b0);
      step("R2", ~(4'b0001 << s), 12'h055, 1'b0, 1'b0, 3'b000, 1'b0);
      step("R2", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
    end
    ch_sel_i = 2'd0;

    // enable gate, including while full
    fifo_en_i = 1'b0;
    step("R3", 4'hF, 12'h321, 1'b0, 1'b0, 3'b000, 1'b0);
    fifo_en_i = 1'b1;
    for (int i = 0; i < 32; i++) step("R3", 4'b0001, 12'(i + 64), 1'b0, 1'b0, 3'b000, 1'b0);
    fifo_en_i = 1'b0;
    step("R3", 4'b0001, 12'h7FF, 1'b0, 1'b0, 3'b000, 1'b0);
    fifo_en_i = 1'b1;
    // full with write and read together: fullness uses count before the read
    step("R8", 4'b0001, 12'h6AA, 1'b0, 1'b1, 3'b000, 1'b0);
    step("R1", 4'b0001, 12'h5AA, 1'b1, 1'b1, 3'b000, 1'b1);

    // simultaneous write and read from small counts
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < c; i++) step("R13", 4'b0001, 12'(c * 16 + i), 1'b0, 1'b0, 3'b000, 1'b0);
      step("R13", 4'b0001, 12'(c * 16 + 9), (c == 2), 1'b1, 3'b000, 1'b0);
      step("R13", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
      step("R13", 4'b0, 12'h0, 1'b0, 1'b1, 3'b000, 1'b0);
      step("R1", 4'b0, 12'h0, 1'b0, 1'b0, 3'b000, 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule